// File: doc/BRIEF.md
# System Tick Timer with Single Compare Channel

This peripheral keeps a free-running tick count twice the width of its register bus and raises an interrupt when the low half of that count reaches a programmed value. Software reads the count as two separate words, low and high. Neither read latches the other word, so a carry from the low word into the high word can fall between the two reads. The usual guard is to read the high word, then the low word, then the high word again, and to retry if the two high values differ. The hardware keeps both words live on every cycle so that this sequence works.

To schedule an event, software reads the low word, adds a delay and writes the sum to the compare register. The sum wraps modulo the word size. Software then sets the enable bit in the control/status register. A sticky match flag records the hit. The interrupt line is the flag gated by the enable. Software clears the flag by writing a one to its bit. The same write may also clear the enable.

The bus is a plain single-cycle write port with combinational read data. A word is selected by address bits [3:2], and address bits [1:0] are ignored.

Top module: `sys_tick_timer`

## Requirements
- R1: During and right after reset, the count, the compare value, the enable and the match flag read as zero, and `irq` is low.
- R2: The count increases by one on every clock after reset. The low word reads at offset 0x4 and the high word at offset 0x8. Every read returns the live value, and the high word steps by one in the same cycle that the low word wraps from all-ones to zero.
- R3: Writes to offsets 0x4 and 0x8 leave the count unchanged.
- R4: The compare register at offset 0xC stores a full data word on write and returns it on read.
- R5: Bit 4 of the control/status register at offset 0x0 is the enable. A write loads it from the written bit 4, and it reads back in that same position.
- R6: If the enable is set and the low count word equals the compare value at a clock edge, the match flag (bit 0 at offset 0x0) is set after that edge. At that point the low word reads compare+1.
- R7: The match flag stays set until a control write with bit 0 equal to one. A write with bit 0 equal to zero leaves it unchanged, and clearing the enable does not clear it.
- R8: `irq` is high exactly when both the match flag and the enable are set. A single write of 0x01 to offset 0x0 drops `irq` on the following cycle.
- R9: When a match and a flag-clearing write fall on the same edge, the match wins and the flag stays set.
- R10: A compare value of low+d, taken modulo the word size, with d from 6 up to the largest word value, gives exactly one match, and that match comes when the count reaches that value.
- R11: Bits of the control/status register other than 0 and 4 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count advances on each rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 4 | Byte address; bits [3:2] select the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the selected register |
| irq | output | 1 | Level interrupt: match flag AND enable |

## Verification
Read data is combinational, so a register written at one rising edge reads back at the falling edge that follows it. Count words are compared against a cycle total that the bench keeps from the first edge after reset. The match flag and `irq` change one edge after the count equals the compare value. The bench therefore waits for the first falling edge at which the flag reads one and expects the low word to read compare+1 there. This pins both when the match occurs and that it occurs only once. For the coincident clear, the write is driven at the falling edge where the low word still equals the compare value, so that the write and the match land on the same rising edge.

// File: rtl/timer_pkg.sv
// Shared register-select codes and control bit positions for the tick timer.
// Assumes a word-aligned bus where address bits [3:2] pick the register.
package timer_pkg;
    localparam int BUS_ADDR_W  = 4;
    localparam int FLAG_BIT    = 0;
    localparam int EN_BIT      = 4;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2,
        SEL_CMP  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tick_counter.sv
// Free-running up-counter of CNT_W bits with no load or hold input.
// Assumes a synchronous active-low reset; wraps to zero at all-ones.
module tick_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);
    // Advance the count on every clock after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/compare_unit.sv
// Compare register, enable bit and sticky match flag for one channel.
// Assumes DATA_W > EN_BIT. A match found at a clock edge takes priority
// over a clearing write at that same edge.
module compare_unit
    import timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cnt_lo,
    input  logic              cmp_we,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cmp_value,
    output logic              cmp_en,
    output logic              match_flag
);
    logic hit;

    // Equality of the live low word and the armed compare value.
    always_comb hit = cmp_en && (cnt_lo == cmp_value);

    // Hold the programmed compare value.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_value <= '0;
        else if (cmp_we) cmp_value <= wdata;
    end

    // Load the enable from every control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       cmp_en <= 1'b0;
        else if (ctrl_we) cmp_en <= wdata[EN_BIT];
    end

    // Sticky flag: set by a hit, cleared by write-one, hit wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n)                            match_flag <= 1'b0;
        else if (hit)                          match_flag <= 1'b1;
        else if (ctrl_we && wdata[FLAG_BIT])   match_flag <= 1'b0;
    end
endmodule

// File: rtl/sys_tick_timer.sv
// Top of the tick timer: decodes the register bus, muxes read data and
// gates the interrupt. Assumes single-cycle writes and combinational reads.
module sys_tick_timer
    import timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  irq
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] cmp_q;
    logic              en_q;
    logic              flag_q;
    reg_sel_e          sel;
    logic              unused_addr_bits;

    // Word select from the address; the byte-lane bits are not used.
    always_comb sel = reg_sel_e'(bus_addr[3:2]);
    assign unused_addr_bits = ^bus_addr[1:0];

    tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .count (cnt)
    );

    compare_unit #(.DATA_W(DATA_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_lo     (cnt[DATA_W-1:0]),
        .cmp_we     (bus_wr && (sel == SEL_CMP)),
        .ctrl_we    (bus_wr && (sel == SEL_CTRL)),
        .wdata      (bus_wdata),
        .cmp_value  (cmp_q),
        .cmp_en     (en_q),
        .match_flag (flag_q)
    );

    // Interrupt is the pending flag gated by the enable.
    always_comb irq = flag_q && en_q;

    // Read mux over the four registers; status bits outside 0 and 4 read 0.
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_CTRL: begin
                bus_rdata[FLAG_BIT] = flag_q;
                bus_rdata[EN_BIT]   = en_q;
            end
            SEL_LO:  bus_rdata = cnt[DATA_W-1:0];
            SEL_HI:  bus_rdata = cnt[CNT_W-1:DATA_W];
            SEL_CMP: bus_rdata = cmp_q;
        endcase
    end
endmodule

// Property checker for the tick timer, attached through bind below.
// Assumes the same DATA_W as the instance it watches.
module sys_tick_timer_chk
    import timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic [BUS_ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic [2*DATA_W-1:0]   cnt,
    input logic [DATA_W-1:0]     cmp_q,
    input logic                  en_q,
    input logic                  flag_q,
    input logic                  irq
);
    logic ctrl_clear;
    logic armed_hit;
    assign ctrl_clear = bus_wr && (bus_addr[3:2] == 2'd0) && bus_wdata[FLAG_BIT];
    assign armed_hit  = en_q && (cnt[DATA_W-1:0] == cmp_q);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cnt == '0 && cmp_q == '0 && !en_q && !flag_q && !irq));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> cnt == $past(cnt) + 1'b1);

    assert_match_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed_hit |=> flag_q);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !ctrl_clear) |=> flag_q);

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_clear && !armed_hit) |=> !flag_q);

    assert_irq_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !irq);

    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q);

    assert_tie_keeps_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_clear && armed_hit) |=> flag_q);

    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(armed_hit));
endmodule

bind sys_tick_timer sys_tick_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt       (cnt),
    .cmp_q     (cmp_q),
    .en_q      (en_q),
    .flag_q    (flag_q),
    .irq       (irq)
);

// File: tb/tb_sys_tick_timer.sv
// Bench for the tick timer with an 8-bit word, so that carries and compare
// wraps are reached in a few hundred cycles.
module tb_sys_tick_timer;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [3:0]   bus_addr = 4'h0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         irq;

    int tests = 0;
    int fails = 0;
    logic [63:0] cyc;

    sys_tick_timer #(.DATA_W(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Cycle total since reset release, the arithmetic model of the count.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 64'd0;
        else        cyc <= cyc + 64'd1;
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [W-1:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // Called just after a falling edge; returns at the next falling edge.
    task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] v, lo, hi, h0, base, cmpv;
        int deltas [9] = '{6, 7, 9, 31, 64, 128, 200, 254, 255};

        // R1: reset state
        repeat (3) @(negedge clk);
        rd(4'h0, v); check("R1", "status in reset", v, 0);
        rd(4'h4, v); check("R1", "low in reset", v, 0);
        rd(4'h8, v); check("R1", "high in reset", v, 0);
        rd(4'hC, v); check("R1", "compare in reset", v, 0);
        check("R1", "irq in reset", irq, 0);
        rst_n = 1'b1;

        // R2: live count equals cycles since reset
        repeat (5) @(negedge clk);
        rd(4'h4, lo); rd(4'h8, hi);
        check("R2", "count after 5", {hi, lo}, cyc[2*W-1:0]);

        // R2: carry into high word, no latching between words
        @(negedge clk); rd(4'h4, lo);
        while (lo != 8'hFF) begin @(negedge clk); rd(4'h4, lo); end
        rd(4'h8, h0);
        @(negedge clk);
        rd(4'h8, hi); rd(4'h4, lo);
        check("R2", "high after carry", hi, h0 + 8'd1);
        check("R2", "low after carry", lo, 0);

        // R3: writes to count words ignored
        wr(4'h4, 8'h5A);
        wr(4'h8, 8'hA5);
        rd(4'h4, lo); rd(4'h8, hi);
        check("R3", "count after writes", {hi, lo}, cyc[2*W-1:0]);

        // R4: compare read/write
        wr(4'hC, 8'h3C); rd(4'hC, v); check("R4", "compare readback", v, 8'h3C);
        wr(4'hC, 8'hC3); rd(4'hC, v); check("R4", "compare readback 2", v, 8'hC3);

        // R5, R11: enable readback with a far-off compare value
        rd(4'h4, lo); wr(4'hC, lo + 8'd100);
        wr(4'h0, 8'hFE);
        rd(4'h0, v); check("R11", "status with all bits written", v, 8'h10);
        wr(4'h0, 8'h00);
        rd(4'h0, v); check("R5", "enable cleared", v, 8'h00);

        // R6, R10: delta sweep, match exactly at compare, wrap included
        foreach (deltas[i]) begin
            wr(4'h0, 8'h01);
            check("R8", "irq after clear+disable", irq, 0);
            rd(4'h4, base);
            cmpv = base + deltas[i][W-1:0];
            wr(4'hC, cmpv);
            wr(4'h0, 8'h10);
            v = '0;
            for (int k = 0; k < 300; k++) begin
                rd(4'h0, v);
                if (v[0]) break;
                @(negedge clk);
            end
            rd(4'h4, lo);
            check("R10", $sformatf("match point d=%0d", deltas[i]), lo, cmpv + 8'd1);
            check("R6", "flag and enable", v, 8'h11);
            check("R8", "irq on match", irq, 1);
            if (i == 3) begin
                // R7: flag sticky when disabled and on write-zero
                wr(4'h0, 8'h00);
                rd(4'h0, v); check("R7", "flag kept after disable", v, 8'h01);
                check("R8", "irq gated off", irq, 0);
                wr(4'h0, 8'h10);
                rd(4'h0, v); check("R7", "flag kept on write-zero", v, 8'h11);
                check("R8", "irq back on", irq, 1);
                wr(4'h0, 8'h11);
                rd(4'h0, v); check("R7", "write-one clears", v, 8'h10);
                check("R8", "irq after clear", irq, 0);
            end
        end

        // R9: clear coinciding with a match leaves flag set
        @(negedge clk); rd(4'h4, lo);
        while (lo != cmpv) begin @(negedge clk); rd(4'h4, lo); end
        wr(4'h0, 8'h11);
        rd(4'h0, v); check("R9", "flag survives tie", v, 8'h11);
        wr(4'h0, 8'h11);
        rd(4'h0, v); check("R7", "clear without tie", v, 8'h10);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule